// File: doc/BRIEF.md
# FP64 Multiply Special-Operand Handler

This block is the front end of a double-precision multiplier. It takes two binary64 operands, a per-exception trap-enable vector and the current sticky exception flags. It decides whether the product is a special case: a NaN operand, an infinity, a zero, or the invalid product of infinity and zero. For a special case it produces the final 64-bit result, the updated sticky flags and, when the raised exception is trap-enabled, a trap request in place of the register write. For an ordinary product of two finite nonzero values (normal or subnormal) it raises a pass-through flag, so that the rounding multiplier further down the pipe computes the value. The XOR sign of the product is reported for every operand pair.

The operands enter through a valid/ready handshake, and the outcome leaves through another one. A two-state controller holds one registered result. In `EMPTY` the slot is free and `LOAD` (an accepted input) moves it to `FULL`. In `FULL`, `STALL` (consumer not ready) keeps the slot, `REFILL` (consumer ready while a new input is accepted) stays in `FULL` with new contents, and `DRAIN` (consumer ready, no new input) returns to `EMPTY`. This gives one result per clock when the consumer never stalls.

Flag and trap-enable bit 0 is the invalid-operation exception. Bits 1 to 4 are reserved for the downstream datapath's exceptions. This block never raises them, and their enables do nothing here.

Top module: `fpm_special_unit`

## Requirements
- R1: After reset `out_valid` is 0. An input is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and its outcome appears on the outputs after that edge. `in_ready` is 1 when no result is held or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged.
- R2: `out_sign` equals the XOR of the two operand sign bits (bit W-1) for every accepted pair. Infinity and zero results carry this sign in bit W-1.
- R3: Infinity times zero, in either operand order, is invalid. Without a trap, the result is the default quiet NaN: sign 0, exponent all ones, and only the top mantissa bit set.
- R4: If operand A is a signaling NaN (exponent all ones, mantissa nonzero, top mantissa bit 0), the result is A with its top mantissa bit set, and invalid is raised.
- R5: If operand B is a signaling NaN and operand A is not a signaling NaN, the result is B with its top mantissa bit set, and invalid is raised. This holds when A is a quiet NaN, an infinity or any other value.
- R6: A quiet NaN operand is returned unchanged, with no new flag, when no signaling NaN outranks it. A is chosen before B when both are quiet NaNs.
- R7: Infinity times a non-NaN, nonzero operand (finite or infinite) gives infinity: XOR sign, exponent all ones, mantissa zero, and no new flag.
- R8: Zero times a finite operand gives a zero with the XOR sign and no new flag.
- R9: When both operands are finite and nonzero, `out_pass` is 1, `out_wr_en` is 0, `out_trap` is 0, the flags are unchanged and `out_result` is 0.
- R10: When invalid is raised and trap-enable bit 0 is 1, then `out_trap` is 1, `out_trap_cause` has bit 0 set, `out_wr_en` is 0, `out_result` is 0 and `out_flags` equals the incoming flags. Otherwise, in every special case, `out_wr_en` is 1 and `out_trap` is 0.
- R11: Without a trap, `out_flags` is the incoming flags ORed with the invalid bit (bit 0) when invalid is raised. Bits 1 to 4 of the flags pass through untouched, and trap-enable bits 1 to 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can accept an operand pair |
| in_op_a | input | W (64) | Operand A |
| in_op_b | input | W (64) | Operand B |
| in_trap_en | input | 5 | Per-exception trap enables, bit 0 invalid |
| in_flags | input | 5 | Current sticky exception flags |
| out_valid | output | 1 | Outcome held |
| out_ready | input | 1 | Consumer takes the outcome |
| out_result | output | W (64) | Special-case result, zero when not written |
| out_sign | output | 1 | XOR sign of the product |
| out_pass | output | 1 | Ordinary product, computed downstream |
| out_wr_en | output | 1 | Destination register is written with out_result |
| out_trap | output | 1 | Trap request, no write |
| out_trap_cause | output | 5 | Exceptions causing the trap |
| out_flags | output | 5 | Updated sticky flags |

## Verification
The bench builds the block with a 4-bit exponent and a 3-bit mantissa, which is an 8-bit format with the same field layout as binary64. All 65,536 operand pairs can then be driven back to back. That covers every NaN payload, both NaN kinds in both positions, subnormals, and both signs of zero and infinity. A second phase offers random pairs with random gaps on the input and random stalls on the output, to exercise the refill, drain and stall transitions. The binary64 default is elaborated but not driven.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int FLAG_W      = 5;
    localparam int FLG_INVALID = 0;
    localparam logic [FLAG_W-1:0] FLAG_INVALID_MASK = FLAG_W'(1) << FLG_INVALID;

    // Operand classification summary.
    typedef struct packed {
        logic zero;
        logic inf;
        logic nan;
        logic snan;
    } fpm_class_t;

    // Which result the special-case decision selects.
    typedef enum logic [2:0] {
        K_PASS,
        K_ZERO,
        K_INF,
        K_NAN_A,
        K_NAN_B,
        K_DEFAULT_NAN
    } fpm_kind_e;

    typedef enum logic {
        S_EMPTY,
        S_FULL
    } fpm_state_e;

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    output fpm_class_t       cls_o
);

    logic exp_max;
    logic exp_min;
    logic man_nz;

    always_comb begin
        exp_max     = &exp_i;
        exp_min     = ~|exp_i;
        man_nz      = |man_i;
        cls_o.zero  = exp_min & ~man_nz;
        cls_o.inf   = exp_max & ~man_nz;
        cls_o.nan   = exp_max & man_nz;
        // Quiet bit is the top mantissa bit; clear means signaling.
        cls_o.snan  = exp_max & man_nz & ~man_i[MAN_W-1];
    end

endmodule

// File: rtl/fpm_priority.sv
module fpm_priority
    import fpm_pkg::*;
(
    input  fpm_class_t a_i,
    input  fpm_class_t b_i,
    output fpm_kind_e  kind_o,
    output logic       invalid_o
);

    always_comb begin
        kind_o    = K_PASS;
        invalid_o = 1'b0;
        if (a_i.nan) begin
            if (a_i.snan) begin
                kind_o    = K_NAN_A;
                invalid_o = 1'b1;
            end else if (b_i.snan) begin
                kind_o    = K_NAN_B;
                invalid_o = 1'b1;
            end else begin
                kind_o    = K_NAN_A;
            end
        end else if (b_i.nan) begin
            kind_o    = K_NAN_B;
            invalid_o = b_i.snan;
        end else if ((a_i.inf && b_i.zero) || (a_i.zero && b_i.inf)) begin
            kind_o    = K_DEFAULT_NAN;
            invalid_o = 1'b1;
        end else if (a_i.inf || b_i.inf) begin
            kind_o    = K_INF;
        end else if (a_i.zero || b_i.zero) begin
            kind_o    = K_ZERO;
        end
    end

endmodule

// File: rtl/fpm_result_build.sv
module fpm_result_build
    import fpm_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    localparam int W     = 1 + EXP_W + MAN_W
) (
    input  fpm_kind_e      kind_i,
    input  logic           sign_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   res_o
);

    localparam logic [MAN_W-1:0] QUIET_MAN = {1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [W-1:0]     QUIET_SET = {{(W-MAN_W){1'b0}}, QUIET_MAN};

    always_comb begin
        unique case (kind_i)
            K_ZERO:        res_o = {sign_i, {(W-1){1'b0}}};
            K_INF:         res_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            K_NAN_A:       res_o = a_i | QUIET_SET;
            K_NAN_B:       res_o = b_i | QUIET_SET;
            K_DEFAULT_NAN: res_o = {1'b0, {EXP_W{1'b1}}, QUIET_MAN};
            default:       res_o = '0;
        endcase
    end

endmodule

// File: rtl/fpm_special_unit.sv
module fpm_special_unit
    import fpm_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    localparam int W     = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [W-1:0]      in_op_a,
    input  logic [W-1:0]      in_op_b,
    input  logic [FLAG_W-1:0] in_trap_en,
    input  logic [FLAG_W-1:0] in_flags,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [W-1:0]      out_result,
    output logic              out_sign,
    output logic              out_pass,
    output logic              out_wr_en,
    output logic              out_trap,
    output logic [FLAG_W-1:0] out_trap_cause,
    output logic [FLAG_W-1:0] out_flags
);

    fpm_state_e state_q;
    fpm_state_e state_nx;
    logic       accept;

    // Classification of both operands (sign bit excluded).
    logic [W-2:0] body [2];
    fpm_class_t   cls  [2];

    assign body[0] = in_op_a[W-2:0];
    assign body[1] = in_op_b[W-2:0];

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpm_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
        ) u_cls (
            .exp_i (body[g][W-2 -: EXP_W]),
            .man_i (body[g][MAN_W-1:0]),
            .cls_o (cls[g])
        );
    end

    fpm_kind_e    kind;
    logic         invalid;
    logic         prod_sign;
    logic [W-1:0] built;

    assign prod_sign = in_op_a[W-1] ^ in_op_b[W-1];

    fpm_priority u_prio (
        .a_i       (cls[0]),
        .b_i       (cls[1]),
        .kind_o    (kind),
        .invalid_o (invalid)
    );

    fpm_result_build #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_build (
        .kind_i (kind),
        .sign_i (prod_sign),
        .a_i    (in_op_a),
        .b_i    (in_op_b),
        .res_o  (built)
    );

    // Exception raising and per-exception trap suppression.
    logic [FLAG_W-1:0] new_flags;
    logic [FLAG_W-1:0] trap_hit;
    logic              take_trap;
    logic              is_pass;
    logic              do_write;

    always_comb begin
        new_flags = invalid ? FLAG_INVALID_MASK : '0;
        trap_hit  = new_flags & in_trap_en;
        take_trap = |trap_hit;
        is_pass   = (kind == K_PASS);
        do_write  = !is_pass && !take_trap;
    end

    // Next-state logic: LOAD, REFILL, DRAIN, STALL.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_EMPTY: if (accept) state_nx = S_FULL;
            S_FULL:  if (out_ready) state_nx = accept ? S_FULL : S_EMPTY;
            default: state_nx = S_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_nx;
    end

    // Handshake outputs decoded from the state.
    always_comb begin
        out_valid = (state_q == S_FULL);
        in_ready  = (state_q == S_EMPTY) || out_ready;
        accept    = in_valid && in_ready;
    end

    // Result slot, loaded on every accepted pair.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result     <= '0;
            out_sign       <= 1'b0;
            out_pass       <= 1'b0;
            out_wr_en      <= 1'b0;
            out_trap       <= 1'b0;
            out_trap_cause <= '0;
            out_flags      <= '0;
        end else if (accept) begin
            out_result     <= do_write ? built : '0;
            out_sign       <= prod_sign;
            out_pass       <= is_pass;
            out_wr_en      <= do_write;
            out_trap       <= take_trap;
            out_trap_cause <= trap_hit;
            out_flags      <= take_trap ? in_flags : (in_flags | new_flags);
        end
    end

endmodule

module fpm_special_chk
    import fpm_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    localparam int W     = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [W-1:0]      out_result,
    input logic              out_pass,
    input logic              out_wr_en,
    input logic              out_trap,
    input logic [FLAG_W-1:0] out_trap_cause,
    input logic [FLAG_W-1:0] out_flags
);

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready |=> out_valid) else $error("accepted pair not presented"); // R1
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_trap) && $stable(out_wr_en)) else $error("outputs moved while stalled"); // R1
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $countones({out_wr_en, out_trap, out_pass}) == 1) else $error("not exactly one of write/trap/pass"); // R10
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_trap |-> !out_wr_en && out_trap_cause[FLG_INVALID] && out_result == '0) else $error("trap wrote a result"); // R10
    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_pass |-> out_result == '0 && out_trap_cause == '0) else $error("pass-through carried a result"); // R9
    AST_NAN_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_wr_en && (&out_result[W-2 -: EXP_W]) && (|out_result[MAN_W-1:0]) |-> out_result[MAN_W-1]) else $error("signaling NaN written"); // R6
    AST_HIGH_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_trap_cause[FLAG_W-1:1] == '0) else $error("reserved exception trapped"); // R11

endmodule

bind fpm_special_unit fpm_special_chk #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_result     (out_result),
    .out_pass       (out_pass),
    .out_wr_en      (out_wr_en),
    .out_trap       (out_trap),
    .out_trap_cause (out_trap_cause),
    .out_flags      (out_flags)
);

// File: tb/tb_fpm_special_unit.sv
module tb_fpm_special_unit;
    import fpm_pkg::*;

    localparam int EXP_W = 4;
    localparam int MAN_W = 3;
    localparam int W     = 1 + EXP_W + MAN_W;
    localparam int V     = 4 + 2 * FLAG_W + W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [W-1:0]      in_op_a = '0;
    logic [W-1:0]      in_op_b = '0;
    logic [FLAG_W-1:0] in_trap_en = '0;
    logic [FLAG_W-1:0] in_flags = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [W-1:0]      out_result;
    logic              out_sign;
    logic              out_pass;
    logic              out_wr_en;
    logic              out_trap;
    logic [FLAG_W-1:0] out_trap_cause;
    logic [FLAG_W-1:0] out_flags;

    always #10 clk = ~clk;

    fpm_special_unit #(.EXP_W(EXP_W), .MAN_W(MAN_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op_a(in_op_a), .in_op_b(in_op_b), .in_trap_en(in_trap_en),
        .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_sign(out_sign), .out_pass(out_pass),
        .out_wr_en(out_wr_en), .out_trap(out_trap),
        .out_trap_cause(out_trap_cause), .out_flags(out_flags)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [V-1:0] exp_q [$];
    string        tag_q [$];

    // Behavioural reference: kinds 0 pass, 1 zero, 2 inf, 3 NaN returned, 4 default NaN.
    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [FLAG_W-1:0] te, input logic [FLAG_W-1:0] fi,
                                  output logic [V-1:0] vec, output string tag);
        int emax = (1 << EXP_W) - 1;
        int qb   = 1 << (MAN_W - 1);
        int ea   = int'(a[W-2:MAN_W]);
        int eb   = int'(b[W-2:MAN_W]);
        int ma   = int'(a[MAN_W-1:0]);
        int mb   = int'(b[MAN_W-1:0]);
        int s    = int'(a[W-1] ^ b[W-1]);
        bit a_nan  = (ea == emax) && (ma != 0);
        bit b_nan  = (eb == emax) && (mb != 0);
        bit a_snan = a_nan && ((ma & qb) == 0);
        bit b_snan = b_nan && ((mb & qb) == 0);
        bit a_inf  = (ea == emax) && (ma == 0);
        bit b_inf  = (eb == emax) && (mb == 0);
        bit a_zero = (ea == 0) && (ma == 0);
        bit b_zero = (eb == 0) && (mb == 0);
        int r = 0;
        bit inv = 0;
        bit pass = 0;
        bit trap, wr;
        logic [FLAG_W-1:0] cause, fl;
        logic [W-1:0] res;
        if (a_snan) begin
            r = int'(a) | qb; inv = 1; tag = "R4";
        end else if (b_snan) begin
            r = int'(b) | qb; inv = 1; tag = "R5";
        end else if (a_nan) begin
            r = int'(a); tag = "R6";
        end else if (b_nan) begin
            r = int'(b); tag = "R6";
        end else if ((a_inf && b_zero) || (a_zero && b_inf)) begin
            r = (emax << MAN_W) | qb; inv = 1; tag = "R3";
        end else if (a_inf || b_inf) begin
            r = (s << (W - 1)) | (emax << MAN_W); tag = "R7";
        end else if (a_zero || b_zero) begin
            r = s << (W - 1); tag = "R8";
        end else begin
            pass = 1; tag = "R9";
        end
        trap = inv && te[0];
        if (trap) begin
            tag = "R10"; wr = 0; cause = FLAG_W'(1); fl = fi; res = '0;
        end else begin
            wr = !pass; cause = '0; fl = fi | FLAG_W'(inv);
            res = pass ? '0 : W'(r);
        end
        vec = {s[0], pass, wr, trap, cause, fl, res};
    endfunction

    // One clock: drive after the falling edge, settle, compare and record.
    task automatic cyc(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [FLAG_W-1:0] te, input logic [FLAG_W-1:0] fi,
                       input logic ordy, output bit took);
        logic [V-1:0] ev;
        logic [V-1:0] got;
        string tg;
        bit held;
        @(negedge clk);
        in_valid = v; in_op_a = a; in_op_b = b;
        in_trap_en = te; in_flags = fi; out_ready = ordy;
        #1;
        held = (exp_q.size() != 0);
        n_cmp++;
        if (out_valid !== held || in_ready !== (!held || ordy)) begin
            n_bad++;
            $display("FAIL R1 handshake: got valid=%b ready=%b expected valid=%b ready=%b",
                     out_valid, in_ready, held, !held || ordy);
        end
        if (held && out_ready) begin
            ev = exp_q.pop_front();
            tg = tag_q.pop_front();
            got = {out_sign, out_pass, out_wr_en, out_trap, out_trap_cause, out_flags, out_result};
            n_cmp++;
            // Every comparison also covers the sign (R2) and the flags (R11).
            if (got !== ev) begin
                n_bad++;
                $display("FAIL %s (sign R2, flags R11): got %h expected %h", tg, got, ev);
            end
        end
        took = v && in_ready;
        if (took) begin
            model(a, b, te, fi, ev, tg);
            exp_q.push_back(ev);
            tag_q.push_back(tg);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        bit took;
        logic [W-1:0] a, b;
        logic [FLAG_W-1:0] te, fi;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 reset: got valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
        end
        rst_n = 1'b1;
        // Exhaustive sweep of every pair, consumer always ready (REFILL path).
        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                cyc(1'b1, W'(i), W'(j), FLAG_W'($urandom), FLAG_W'($urandom), 1'b1, took);
            end
        end
        repeat (2) cyc(1'b0, '0, '0, '0, '0, 1'b1, took);
        // Random gaps and stalls (LOAD, STALL, DRAIN paths).
        repeat (3000) begin
            a = W'($urandom); b = W'($urandom);
            te = FLAG_W'($urandom); fi = FLAG_W'($urandom);
            do begin
                cyc(($urandom % 4) != 0, a, b, te, fi, ($urandom % 3) != 0, took);
            end while (!took);
        end
        repeat (4) cyc(1'b0, '0, '0, '0, '0, 1'b1, took);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: got no completion expected end of run");
            summary();
            $finish;
        end
    end

endmodule